// File: doc/BRIEF.md
# Iterative Word Divider with Overflow Status

This block divides one 32-bit word by another for a core whose registers are 64 bits wide. Each source is 64 bits, and only its low word takes part in the division. A select input picks signed or unsigned division. The quotient always goes out as a 64-bit value whose upper word is zero, even when the quotient is signed and negative. Two control bits set how far the status is updated. One enables the overflow status update. The other asks for a four-bit condition field that describes the result.

A single-cycle start pulse launches an operation while the unit is idle. The unit checks the operands for an impossible division before it starts any iteration. A zero divisor is impossible. A signed division of the most negative word by minus one is also impossible. Such an operation finishes in its first cycle with a zero result, and its overflow is reported through the status outputs. It does not trap. Every other operation runs one quotient bit per cycle through a restoring shift-subtract loop and then reports done.

The condition field is built after the status update, so its last bit is the summary-overflow value that the operation produces. The carry status is not part of this block, and it is never produced.

Top module: `wdiv_unit`

## Requirements
- R1: With `signed_i`=1, the low 32 bits of each source are read as two's-complement values. A valid quotient truncates toward zero. It is placed in `result_o[31:0]`, and `result_o[63:32]` is 0. The upper 32 bits of both sources have no effect.
- R2: With `signed_i`=0, the low 32 bits are read as unsigned values, and `result_o` = {32'b0, a/b}.
- R3: With `signed_i`=1, a divisor of 0 or the pair 0x80000000 / 0xFFFFFFFF is invalid. An invalid operation gives `result_o`=0 and raises overflow.
- R4: With `signed_i`=0, a divisor of 0 is invalid. It gives `result_o`=0 and raises overflow.
- R5: When `oe_i` was 1 at start, `stat_we_o`=1 at done. `ov_o` and `ov32_o` both equal the invalid flag. `so_o` = `so_i` OR the invalid flag, so a valid division leaves SO at its input value.
- R6: When `oe_i` was 0 at start, `stat_we_o`=0 at done and `ov_o`=`ov32_o`=0, even for an invalid division. `so_o` carries `so_i` through unchanged.
- R7: `cr_we_o` equals the `rc_i` captured at start. When it is 1, `cr_o`[3:0] = {result<0, result>0, result==0, so_o}, where the compare treats the 64-bit result as signed. Because the result is zero-extended, bit 3 is always 0. When it is 0, `cr_o`=0.
- R8: If `start_i` is high in cycle c, then `done_o` is high in cycle c+1 for an invalid operation and in cycle c+33 for a valid one. `busy_o` is high from cycle c+1 through cycle c+32 for a valid operation.
- R9: `start_i` is ignored while `busy_o` is high. `done_o` lasts one cycle. The result, status and condition outputs hold their values until the next accepted start completes.
- R10: After reset, `busy_o`, `done_o`, `result_o`, `ov_o`, `ov32_o`, `so_o`, `stat_we_o`, `cr_we_o` and `cr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| signed_i | input | 1 | 1 = signed division, 0 = unsigned |
| src_a_i | input | 64 | Dividend source, low word used |
| src_b_i | input | 64 | Divisor source, low word used |
| oe_i | input | 1 | Enable overflow status update |
| rc_i | input | 1 | Enable condition field update |
| so_i | input | 1 | Current summary-overflow bit |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Zero-extended quotient |
| ov_o | output | 1 | Overflow bit to write |
| ov32_o | output | 1 | 32-bit overflow bit to write |
| so_o | output | 1 | Summary-overflow bit to write |
| stat_we_o | output | 1 | Status bits are to be written |
| cr_we_o | output | 1 | Condition field is to be written |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench builds the unit with its default widths: a 64-bit datapath and a 32-bit word. At these widths the edge operands can be written out directly: the most negative word, minus one, the all-ones unsigned word, and dividends smaller than the divisor. The 33-cycle latency can also be timed exactly on every operation. Random signed and unsigned operands are mixed with garbage in the upper source bits. Every pairing of the overflow-enable and condition-enable bits, together with both input SO values, is exercised against a bench reference model.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
    // Bit positions inside the condition field
    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;

    typedef enum logic {
        DIV_UNSIGNED = 1'b0,
        DIV_SIGNED   = 1'b1
    } div_kind_e;
endpackage

// File: rtl/wdiv_prep.sv
// Operand conditioning: magnitudes, quotient sign and invalid detection.
module wdiv_prep
    import wdiv_pkg::*;
#(
    parameter int WLEN = 32
) (
    input  div_kind_e        kind_i,
    input  logic [WLEN-1:0]  a_i,
    input  logic [WLEN-1:0]  b_i,
    output logic [WLEN-1:0]  mag_a_o,
    output logic [WLEN-1:0]  mag_b_o,
    output logic             neg_o,
    output logic             invalid_o
);
    localparam logic [WLEN-1:0] MOST_NEG = {1'b1, {(WLEN-1){1'b0}}};
    localparam logic [WLEN-1:0] MINUS_ONE = {WLEN{1'b1}};

    logic sa, sb;
    logic zero_div, min_by_m1;

    always_comb begin
        sa        = (kind_i == DIV_SIGNED) && a_i[WLEN-1];
        sb        = (kind_i == DIV_SIGNED) && b_i[WLEN-1];
        mag_a_o   = sa ? (~a_i + 1'b1) : a_i;
        mag_b_o   = sb ? (~b_i + 1'b1) : b_i;
        neg_o     = sa ^ sb;
        zero_div  = (b_i == '0);
        min_by_m1 = (kind_i == DIV_SIGNED) && (a_i == MOST_NEG) && (b_i == MINUS_ONE);
        invalid_o = zero_div || min_by_m1;
    end
endmodule

// File: rtl/wdiv_step.sv
// One restoring shift-subtract iteration.
module wdiv_step #(
    parameter int WLEN = 32
) (
    input  logic [WLEN:0]    rem_i,
    input  logic [WLEN-1:0]  quo_i,
    input  logic [WLEN-1:0]  dvs_i,
    output logic [WLEN:0]    rem_o,
    output logic [WLEN-1:0]  quo_o
);
    logic [WLEN:0] shifted;
    logic [WLEN:0] trial;

    always_comb begin
        shifted = {rem_i[WLEN-1:0], quo_i[WLEN-1]};
        trial   = shifted - {1'b0, dvs_i};
        if (shifted >= {1'b0, dvs_i}) begin
            rem_o = trial;
            quo_o = {quo_i[WLEN-2:0], 1'b1};
        end else begin
            rem_o = shifted;
            quo_o = {quo_i[WLEN-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/wdiv_flags.sv
// Status merge and condition field generation at completion.
module wdiv_flags
    import wdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             invalid_i,
    input  logic             oe_i,
    input  logic             rc_i,
    input  logic             so_i,
    input  logic [XLEN-1:0]  res_i,
    output logic             ov_o,
    output logic             ov32_o,
    output logic             so_o,
    output logic             stat_we_o,
    output logic             cr_we_o,
    output logic [3:0]       cr_o
);
    always_comb begin
        stat_we_o = oe_i;
        ov_o      = oe_i && invalid_i;
        ov32_o    = oe_i && invalid_i;
        so_o      = so_i || (oe_i && invalid_i);
        cr_we_o   = rc_i;
        cr_o      = '0;
        if (rc_i) begin
            cr_o[CR_LT] = $signed(res_i) < 0;
            cr_o[CR_GT] = $signed(res_i) > 0;
            cr_o[CR_EQ] = (res_i == '0);
            cr_o[CR_SO] = so_o;
        end
    end
endmodule

// File: rtl/wdiv_unit.sv
// Iterative word divider, top level.
module wdiv_unit
    import wdiv_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [XLEN-1:0]  src_a_i,
    input  logic [XLEN-1:0]  src_b_i,
    input  logic             oe_i,
    input  logic             rc_i,
    input  logic             so_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [XLEN-1:0]  result_o,
    output logic             ov_o,
    output logic             ov32_o,
    output logic             so_o,
    output logic             stat_we_o,
    output logic             cr_we_o,
    output logic [3:0]       cr_o
);
    localparam int CW = $clog2(WLEN + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [WLEN:0]    rem;
        logic [WLEN-1:0]  quo;
        logic [WLEN-1:0]  dvs;
        logic             neg;
        logic             oe;
        logic             rc;
        logic             so_in;
        logic [XLEN-1:0]  res;
        logic             ov;
        logic             ov32;
        logic             so;
        logic             stat_we;
        logic             cr_we;
        logic [3:0]       cr;
    } state_t;

    state_t st_d, st_q;

    // Upper source bits never take part in the division
    logic unused_hi;
    assign unused_hi = ^{src_a_i[XLEN-1:WLEN], src_b_i[XLEN-1:WLEN]};

    div_kind_e       kind;
    logic [WLEN-1:0] p_mag_a, p_mag_b;
    logic            p_neg, p_invalid;

    assign kind = div_kind_e'(signed_i);

    wdiv_prep #(.WLEN(WLEN)) u_prep (
        .kind_i    (kind),
        .a_i       (src_a_i[WLEN-1:0]),
        .b_i       (src_b_i[WLEN-1:0]),
        .mag_a_o   (p_mag_a),
        .mag_b_o   (p_mag_b),
        .neg_o     (p_neg),
        .invalid_o (p_invalid)
    );

    logic [WLEN:0]   s_rem;
    logic [WLEN-1:0] s_quo;

    wdiv_step #(.WLEN(WLEN)) u_step (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .dvs_i (st_q.dvs),
        .rem_o (s_rem),
        .quo_o (s_quo)
    );

    logic            fin_go, fin_inv, fin_oe, fin_rc, fin_so;
    logic [XLEN-1:0] fin_res;
    logic [WLEN-1:0] q_fix;
    logic            f_ov, f_ov32, f_so, f_stat_we, f_cr_we;
    logic [3:0]      f_cr;

    wdiv_flags #(.XLEN(XLEN)) u_flags (
        .invalid_i (fin_inv),
        .oe_i      (fin_oe),
        .rc_i      (fin_rc),
        .so_i      (fin_so),
        .res_i     (fin_res),
        .ov_o      (f_ov),
        .ov32_o    (f_ov32),
        .so_o      (f_so),
        .stat_we_o (f_stat_we),
        .cr_we_o   (f_cr_we),
        .cr_o      (f_cr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        fin_go    = 1'b0;
        fin_inv   = 1'b0;
        fin_oe    = st_q.oe;
        fin_rc    = st_q.rc;
        fin_so    = st_q.so_in;
        fin_res   = '0;
        q_fix     = st_q.neg ? (~s_quo + 1'b1) : s_quo;

        if (!st_q.busy) begin
            if (start_i) begin
                st_d.oe    = oe_i;
                st_d.rc    = rc_i;
                st_d.so_in = so_i;
                st_d.neg   = p_neg;
                st_d.dvs   = p_mag_b;
                st_d.quo   = p_mag_a;
                st_d.rem   = '0;
                st_d.cnt   = CW'(WLEN);
                if (p_invalid) begin
                    fin_go  = 1'b1;
                    fin_inv = 1'b1;
                    fin_oe  = oe_i;
                    fin_rc  = rc_i;
                    fin_so  = so_i;
                end else begin
                    st_d.busy = 1'b1;
                end
            end
        end else begin
            st_d.rem = s_rem;
            st_d.quo = s_quo;
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                fin_go    = 1'b1;
                fin_res   = {{(XLEN-WLEN){1'b0}}, q_fix};
            end
        end

        if (fin_go) begin
            st_d.done    = 1'b1;
            st_d.res     = fin_res;
            st_d.ov      = f_ov;
            st_d.ov32    = f_ov32;
            st_d.so      = f_so;
            st_d.stat_we = f_stat_we;
            st_d.cr_we   = f_cr_we;
            st_d.cr      = f_cr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign result_o  = st_q.res;
    assign ov_o      = st_q.ov;
    assign ov32_o    = st_q.ov32;
    assign so_o      = st_q.so;
    assign stat_we_o = st_q.stat_we;
    assign cr_we_o   = st_q.cr_we;
    assign cr_o      = st_q.cr;
endmodule

// File: rtl/wdiv_unit_chk.sv
module wdiv_unit_chk #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic [XLEN-1:0]  result_o,
    input logic             ov_o,
    input logic             ov32_o,
    input logic             so_o,
    input logic             stat_we_o,
    input logic             cr_we_o,
    input logic [3:0]       cr_o
);
    localparam int RW = $clog2(WLEN + 2);
    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_cnt <= '0;
        else if (busy_o) run_cnt <= run_cnt + 1'b1;
        else             run_cnt <= '0;
    end

    p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_cnt < RW'(WLEN)));
    p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (busy_o || done_o));
    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(done_o) && busy_o) |-> $stable(result_o));
    p_zero_on_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ov_o) |-> (result_o == '0));
    p_so_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && stat_we_o && ov_o) |-> (so_o && ov32_o));
    p_no_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !stat_we_o) |-> (!ov_o && !ov32_o));
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o[XLEN-1:WLEN] == '0));
    p_cr_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cr_we_o) |-> (!cr_o[3] && $onehot0(cr_o[3:1]) && (cr_o[0] == so_o)));
    p_cr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cr_we_o) |-> (cr_o == 4'b0));
endmodule

bind wdiv_unit wdiv_unit_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .ov_o      (ov_o),
    .ov32_o    (ov32_o),
    .so_o      (so_o),
    .stat_we_o (stat_we_o),
    .cr_we_o   (cr_we_o),
    .cr_o      (cr_o)
);

// File: tb/tb_wdiv_unit.sv
`timescale 1ns/1ps
module tb_wdiv_unit;
    localparam int XLEN = 64;
    localparam int WLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, signed_i = 1'b0, oe_i = 1'b0, rc_i = 1'b0, so_i = 1'b0;
    logic [XLEN-1:0] src_a_i = '0, src_b_i = '0;
    logic busy_o, done_o, ov_o, ov32_o, so_o, stat_we_o, cr_we_o;
    logic [XLEN-1:0] result_o;
    logic [3:0] cr_o;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wdiv_unit #(.XLEN(XLEN), .WLEN(WLEN)) dut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model
    function automatic logic [64:0] ref_div(logic sg, logic [31:0] a, logic [31:0] b);
        logic signed [31:0] sa, sb, sq;
        logic inv;
        logic [31:0] q;
        sa = a; sb = b;
        inv = (b == 0) || (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
        if (inv) q = 0;
        else if (sg) begin sq = sa / sb; q = sq; end
        else q = a / b;
        return {inv, 32'h0, q};
    endfunction

    task automatic run_op(logic sg, logic [63:0] a, logic [63:0] b, logic oe, logic rc, logic so);
        logic [64:0] r;
        logic inv, eso;
        logic [63:0] er;
        logic [3:0] ecr;
        int cyc;
        r = ref_div(sg, a[31:0], b[31:0]);
        inv = r[64]; er = r[63:0];
        @(negedge clk);
        signed_i = sg; src_a_i = a; src_b_i = b; oe_i = oe; rc_i = rc; so_i = so; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        so_i = ~so;
        cyc = 1;
        if (!inv) chk("R8 busy during iteration", {63'b0, busy_o}, 64'd1);
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk("R8 latency", cyc, inv ? 1 : WLEN + 1);
        chk(sg ? (inv ? "R3 signed invalid result" : "R1 signed result")
               : (inv ? "R4 unsigned invalid result" : "R2 unsigned result"), result_o, er);
        eso = so | (oe & inv);
        if (oe) begin
            chk("R5 stat_we", {63'b0, stat_we_o}, 64'd1);
            chk("R5 ov", {63'b0, ov_o}, {63'b0, inv});
            chk("R5 ov32", {63'b0, ov32_o}, {63'b0, inv});
            chk("R5 so", {63'b0, so_o}, {63'b0, eso});
        end else begin
            chk("R6 stat_we", {63'b0, stat_we_o}, 64'd0);
            chk("R6 ov/ov32", {62'b0, ov_o, ov32_o}, 64'd0);
            chk("R6 so", {63'b0, so_o}, {63'b0, so});
        end
        ecr = rc ? {1'b0, er != 0, er == 0, eso} : 4'b0;
        chk("R7 cr_we", {63'b0, cr_we_o}, {63'b0, rc});
        chk("R7 cr", {60'b0, cr_o}, {60'b0, ecr});
        @(negedge clk);
        chk("R9 done one cycle", {63'b0, done_o}, 64'd0);
        chk("R9 result held", result_o, er);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R10 reset busy/done", {62'b0, busy_o, done_o}, 64'd0);
        chk("R10 reset result", result_o, 64'd0);
        chk("R10 reset flags", {57'b0, ov_o, ov32_o, so_o, stat_we_o, cr_we_o, cr_o != 0}, 64'd0);
        rst_n = 1'b1;

        // Directed corners
        run_op(1, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_FFFF_FFFF, 1, 1, 0); // R3 min / -1
        run_op(1, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0); // R3 + R6
        run_op(1, 64'd17, 64'h1234_5678_0000_0000, 1, 0, 1);                   // R3 zero divisor
        run_op(0, 64'd99, 64'd0, 1, 1, 0);                                      // R4
        run_op(0, 64'd99, 64'd0, 0, 0, 1);                                      // R4 + R6
        run_op(0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1, 1, 0);   // R2 unsigned, no invalid
        run_op(1, 64'h0000_0000_FFFF_FFF9, 64'd2, 1, 1, 1);                     // R1 -7/2 = -3
        run_op(1, 64'd7, 64'h0000_0000_FFFF_FFFE, 0, 1, 0);                     // R1 7/-2
        run_op(1, 64'h0000_0000_8000_0000, 64'd1, 1, 1, 0);                     // R1 min / 1
        run_op(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 1);                     // R2
        run_op(0, 64'd3, 64'd5, 1, 1, 0);                                       // R2/R7 zero quotient
        run_op(1, 64'hABCD_0000_0000_0064, 64'h5555_0000_0000_0007, 1, 1, 0);   // R1 upper bits ignored

        // R9: start while busy is ignored
        @(negedge clk);
        signed_i = 0; src_a_i = 64'd1000; src_b_i = 64'd10; oe_i = 1; rc_i = 1; so_i = 0; start_i = 1;
        @(posedge clk); @(negedge clk);
        start_i = 0;
        repeat (5) @(negedge clk);
        src_a_i = 64'd5; src_b_i = 64'd0; start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk("R9 start ignored while busy", {62'b0, busy_o, done_o}, 64'd2);
        repeat (26) @(negedge clk);
        chk("R9 original completion", {63'b0, done_o}, 64'd1);
        chk("R9 original result", result_o, 64'd100);
        chk("R9 no overflow from ignored op", {63'b0, ov_o}, 64'd0);
        held = result_o;
        repeat (3) @(negedge clk);
        chk("R9 idle hold", result_o, held);

        // Random mix
        for (int i = 0; i < 240; i++) begin
            logic [63:0] a, b;
            logic sg;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            sg = $urandom % 2;
            case ($urandom % 8)
                0: b[31:0] = 0;
                1: b[31:0] = {$urandom % 16};
                2: begin a[31:0] = 32'h8000_0000; b[31:0] = 32'hFFFF_FFFF; end
                3: b[31:0] = b[31:0] >> ($urandom % 31);
                default: ;
            endcase
            run_op(sg, a, b, $urandom % 2, $urandom % 2, $urandom % 2);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule